// File: doc/BRIEF.md
# Triggered Multi-Channel Pulse Generator

This block fires one timed pulse across a chosen group of output channels. A shared free-running time base (the counter) comes in as an input. Software sets up a start offset, an active length, a channel enable mask, a per-channel active level and a trigger source. A rising edge on the selected trigger input captures the counter value. The block then counts off the start offset in counter ticks and drives every enabled channel to its active level for the programmed number of ticks.

All enabled channels are driven from the same state register, so they change on the same clock edge. Several outputs can therefore be fired in phase from one trigger. Offset, length and mask are captured when the trigger is taken, so software may set up the next pulse while the current one runs. A `busy_o` flag shows when a pulse is armed or active.

Top module: `trig_pulse_gen`

## Requirements
- R1: After reset, and at any time no pulse is armed or active, each `pulse_o` bit sits at its inactive level (the complement of its `act_lvl_i` bit) and `busy_o` is low.
- R2: The active phase begins on the clock edge at which the counter has advanced by `start_off_i` ticks from the value captured with the trigger. An offset of 0 makes the pulse active from the very edge that takes the trigger.
- R3: The active phase lasts exactly `pulse_len_i` counter ticks and then ends.
- R4: A trigger taken while `pulse_len_i` is 0 produces no pulse, and `busy_o` stays low.
- R5: Only channels whose `chan_en_i` bit was set at trigger time go active. All of them switch on the same clock edge, both at the start and at the end.
- R6: A channel with active-level bit 1 is driven high during the pulse and low outside it. A channel with active-level bit 0 is driven low during the pulse and high outside it.
- R7: `trig_sel_i` picks trigger input index 0 to 3. Edges on the unselected trigger inputs have no effect.
- R8: A trigger is taken only on a rising edge of the selected input. A rising edge that arrives while a pulse is armed or active is ignored, and a level that stays high after the pulse ends does not start a new pulse.
- R9: Offset, length and channel enables are captured when the trigger is taken. Changing them while a pulse is in progress does not alter that pulse.
- R10: Timing counts counter ticks, not clock cycles, using modulo-2^16 differences. A stopped counter holds the pulse in its current phase, and a counter that wraps past 0xFFFF during a pulse does not disturb the timing.
- R11: `busy_o` is high from the edge that takes the trigger until the edge on which the active phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_i | input | 16 | Shared free-running counter value |
| trig_i | input | 4 | Trigger source inputs, synchronous to `clk` |
| trig_sel_i | input | 2 | Index of the trigger source in use |
| chan_en_i | input | 8 | Channels that take part in the next pulse |
| act_lvl_i | input | 8 | Active level of each channel |
| start_off_i | input | 16 | Counter ticks from trigger to the start of the pulse |
| pulse_len_i | input | 16 | Counter ticks the pulse stays active |
| pulse_o | output | 8 | Channel outputs |
| busy_o | output | 1 | A pulse is armed or active |

## Verification
Random pulses use offsets and lengths that include zero, random masks, random polarities and random trigger sources. Each output is compared on every cycle against a timing window worked out in the bench, which separates off-by-one errors at the start edge from off-by-one errors at the end edge. During each pulse the bench re-raises the selected trigger, toggles the unselected triggers and rewrites the configuration inputs. This exposes any retriggering, wrong trigger selection, or configuration that is not held for the length of the pulse. Directed runs cover a stopped counter and a counter that wraps, which tell tick-based timing apart from cycle-based timing and catch broken modular subtraction. They also cover a zero length, an empty mask, and long offsets and lengths.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Phase of the pulse timer
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARM    = 2'd1,
    ST_ACTIVE = 2'd2
  } tpg_state_e;

endpackage

// File: rtl/tpg_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module tpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tpg_trig_sel.sv
// Rising-edge detection on every trigger input and selection of one.
module tpg_trig_sel #(
  parameter int N_TRIG = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              fire_o
);

  logic [N_TRIG-1:0] prev_q;
  logic [N_TRIG-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= trig_i;
    end
  end

  for (genvar g = 0; g < N_TRIG; g++) begin : g_rise
    assign rise[g] = trig_i[g] & ~prev_q[g];
  end

  // An index beyond N_TRIG-1 selects nothing
  always_comb begin
    fire_o = 1'b0;
    for (int i = 0; i < N_TRIG; i++) begin
      if (sel_i == SEL_W'(i)) begin
        fire_o = rise[i];
      end
    end
  end

endmodule

// File: rtl/tpg_timer.sv
// Offset and length timing against the shared counter.
module tpg_timer
  import tpg_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [N_CH-1:0]  mask_i,
  output logic             active_o,
  output logic             busy_o,
  output logic [N_CH-1:0]  mask_o
);

  tpg_state_e       state_q, state_d;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] off_q;
  logic [CNT_W-1:0] len_q;
  logic [N_CH-1:0]  mask_q;
  logic [CNT_W-1:0] elapsed;
  logic             base_en;
  logic             cfg_en;

  // Ticks since the last reference point, modulo 2^CNT_W
  assign elapsed = cnt_i - base_q;

  always_comb begin
    state_d = state_q;
    base_en = 1'b0;
    cfg_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fire_i && (len_i != '0)) begin
          cfg_en  = 1'b1;
          base_en = 1'b1;
          state_d = (off_i == '0) ? ST_ACTIVE : ST_ARM;
        end
      end
      ST_ARM: begin
        if (elapsed >= off_q) begin
          base_en = 1'b1;
          state_d = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (elapsed >= len_q) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= cnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      len_q  <= '0;
      mask_q <= '0;
    end else if (cfg_en) begin
      off_q  <= off_i;
      len_q  <= len_i;
      mask_q <= mask_i;
    end
  end

  assign active_o = (state_q == ST_ACTIVE);
  assign busy_o   = (state_q != ST_IDLE);
  assign mask_o   = mask_q;

endmodule

// File: rtl/tpg_chan_out.sv
// Per-channel output level from the shared active flag.
module tpg_chan_out #(
  parameter int N_CH = 8
) (
  input  logic            active_i,
  input  logic [N_CH-1:0] mask_i,
  input  logic [N_CH-1:0] lvl_i,
  output logic [N_CH-1:0] pulse_o
);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign pulse_o[g] = (active_i && mask_i[g]) ? lvl_i[g] : ~lvl_i[g];
  end

endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
  parameter int N_CH   = 8,
  parameter int N_TRIG = 4,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  trig_sel_i,
  input  logic [N_CH-1:0]   chan_en_i,
  input  logic [N_CH-1:0]   act_lvl_i,
  input  logic [CNT_W-1:0]  start_off_i,
  input  logic [CNT_W-1:0]  pulse_len_i,
  output logic [N_CH-1:0]   pulse_o,
  output logic              busy_o
);

  logic            rst_sync_n;
  logic            fire;
  logic            active;
  logic [N_CH-1:0] mask_w;

  tpg_rst_sync #(
    .STAGES(2)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  tpg_trig_sel #(
    .N_TRIG(N_TRIG),
    .SEL_W (SEL_W)
  ) u_trig (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .trig_i(trig_i),
    .sel_i (trig_sel_i),
    .fire_o(fire)
  );

  tpg_timer #(
    .N_CH (N_CH),
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire_i  (fire),
    .cnt_i   (cnt_i),
    .off_i   (start_off_i),
    .len_i   (pulse_len_i),
    .mask_i  (chan_en_i),
    .active_o(active),
    .busy_o  (busy_o),
    .mask_o  (mask_w)
  );

  tpg_chan_out #(
    .N_CH(N_CH)
  ) u_out (
    .active_i(active),
    .mask_i  (mask_w),
    .lvl_i   (act_lvl_i),
    .pulse_o (pulse_o)
  );

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CH-1:0]  pulse_o,
  input logic [N_CH-1:0]  act_lvl_i,
  input logic [N_CH-1:0]  mask,
  input logic [CNT_W-1:0] pulse_len_i,
  input logic             busy_o
);

  logic [N_CH-1:0] driven;
  assign driven = pulse_o ^ ~act_lvl_i;

  // R1: nothing in progress means every output at its inactive level
  assert_idle_inactive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (pulse_o == ~act_lvl_i));

  // R5: channels outside the captured mask never go active
  assert_mask_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (driven & ~mask) == '0);

  // R5: either no channel or all enabled channels are active together
  assert_in_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (driven == '0) || (driven == mask));

  // R4: a zero length never starts a pulse
  assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (pulse_len_i == '0)) |=> !busy_o);

  // R9: captured enables hold while a pulse runs
  assert_mask_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (mask == $past(mask)));

endmodule

bind trig_pulse_gen tpg_checker #(
  .N_CH (N_CH),
  .CNT_W(CNT_W)
) u_tpg_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .pulse_o    (pulse_o),
  .act_lvl_i  (act_lvl_i),
  .mask       (mask_w),
  .pulse_len_i(pulse_len_i),
  .busy_o     (busy_o)
);

// File: tb/test_trig_pulse_gen.sv
`timescale 1ns/100ps
module test_trig_pulse_gen;

  logic        clk;
  logic        rst_n;
  logic [15:0] cnt;
  bit          cnt_run;
  logic [3:0]  trig;
  logic [1:0]  sel;
  logic [7:0]  en;
  logic [7:0]  lvl;
  logic [15:0] off;
  logic [15:0] len;
  logic [7:0]  pulse;
  logic        busy;

  int checks;
  int fails;

  trig_pulse_gen i_trig_pulse_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt),
    .trig_i     (trig),
    .trig_sel_i (sel),
    .chan_en_i  (en),
    .act_lvl_i  (lvl),
    .start_off_i(off),
    .pulse_len_i(len),
    .pulse_o    (pulse),
    .busy_o     (busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Shared time base, one tick per clock while running
  always @(posedge clk) if (cnt_run) cnt <= cnt + 16'd1;

  function automatic logic [7:0] exp_pat(input bit act, input logic [7:0] m, input logic [7:0] l);
    return act ? ((m & l) | (~m & ~l)) : ~l;
  endfunction

  task automatic check(input logic [7:0] exp_p, input bit exp_b, input string req);
    checks++;
    if (pulse !== exp_p || busy !== exp_b) begin
      fails++;
      $display("FAIL %s actual pulse=%h busy=%b expected pulse=%h busy=%b",
               req, pulse, busy, exp_p, exp_b);
    end
  endtask

  // Fire on trigger s and follow the pulse cycle by cycle
  task automatic run_pulse(input logic [1:0] s, input logic [15:0] o, input logic [15:0] l,
                           input logic [7:0] m, input logic [7:0] lv, input string req);
    int total;
    logic [7:0] keep_m;
    logic [7:0] keep_lv;
    keep_m  = m;
    keep_lv = lv;
    total   = int'(o) + int'(l) + 3;
    @(negedge clk);
    sel = s; off = o; len = l; en = m; lvl = lv;
    trig = 4'($urandom);
    trig[s] = 1'b1;
    for (int j = 0; j < total; j++) begin
      bit ea;
      bit eb;
      @(negedge clk);
      ea = (l != 0) && (j >= int'(o)) && (j < int'(o) + int'(l));
      eb = (l != 0) && (j < int'(o) + int'(l));
      check(exp_pat(ea, keep_m, keep_lv), eb, req);
      // R7: unselected triggers toggle freely
      for (int t = 0; t < 4; t++) if (t != int'(s)) trig[t] = 1'($urandom);
      // R8: drop, then re-raise and hold the selected trigger during the pulse
      if (j == 0) trig[s] = 1'b0;
      if (j == 1 && l != 0 && int'(o) + int'(l) >= 2) trig[s] = 1'b1;
      // R9: configuration rewritten after capture
      if (j == 0) begin
        off = 16'($urandom);
        len = 16'($urandom);
        en  = 8'($urandom);
      end
    end
    @(negedge clk);
    trig = 4'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    int seed_init;
    checks = 0;
    fails  = 0;
    seed_init = $urandom(32'd4711);
    rst_n = 1'b0;
    cnt = 16'd100; cnt_run = 1'b1;
    trig = 4'b0; sel = 2'd0; en = 8'hFF; lvl = 8'hA5;
    off = 16'd0; len = 16'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(~8'hA5, 1'b0, "R1 reset");

    // R2: zero and unit offsets; R3: unit length
    run_pulse(2'd0, 16'd0, 16'd1, 8'hFF, 8'hFF, "R2 R3 off0 len1");
    run_pulse(2'd1, 16'd1, 16'd1, 8'h0F, 8'hF0, "R2 off1 len1");
    run_pulse(2'd2, 16'd5, 16'd3, 8'h81, 8'h81, "R2 R11 off5 len3");
    // R3: long length; R2: long offset
    run_pulse(2'd3, 16'd0, 16'd200, 8'h3C, 8'h55, "R3 long length");
    run_pulse(2'd0, 16'd300, 16'd2, 8'hC3, 8'hAA, "R2 long offset");
    // R4: zero length
    run_pulse(2'd1, 16'd5, 16'd0, 8'hFF, 8'h00, "R4 zero length");
    // R5: empty mask keeps all outputs inactive while busy
    run_pulse(2'd2, 16'd2, 16'd4, 8'h00, 8'hFF, "R5 empty mask");
    // R6: both polarities
    run_pulse(2'd3, 16'd2, 16'd3, 8'hFF, 8'h00, "R6 active low");
    run_pulse(2'd3, 16'd2, 16'd3, 8'hFF, 8'hFF, "R6 active high");

    // R10: counter wraps during the pulse
    @(negedge clk); cnt = 16'hFFFA;
    run_pulse(2'd1, 16'd4, 16'd5, 8'h5A, 8'h33, "R10 wrap");

    // R7: edges only on unselected inputs
    @(negedge clk);
    sel = 2'd2; len = 16'd3; off = 16'd0; en = 8'hFF; lvl = 8'h0F;
    for (int k = 0; k < 12; k++) begin
      trig = (k % 2 == 0) ? 4'b1011 : 4'b0000;
      @(negedge clk);
      check(~8'h0F, 1'b0, "R7 unselected triggers");
    end
    trig = 4'b0;
    @(negedge clk);

    // R10: stopped counter holds the armed phase
    @(negedge clk);
    cnt_run = 1'b0; sel = 2'd1; off = 16'd3; len = 16'd2; en = 8'hFF; lvl = 8'h0F;
    trig = 4'b0010;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      trig = 4'b0;
      check(exp_pat(1'b0, 8'hFF, 8'h0F), 1'b1, "R10 stopped counter");
    end
    cnt_run = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      check(exp_pat(k >= 4 && k < 6, 8'hFF, 8'h0F), k < 6, "R10 resumed counter");
    end

    // Constrained random pulses
    for (int n = 0; n < 40; n++) begin
      logic [1:0]  rs;
      logic [15:0] ro;
      logic [15:0] rl;
      rs = 2'($urandom % 4);
      ro = 16'($urandom % 10);
      rl = 16'($urandom % 8);
      run_pulse(rs, ro, rl, 8'($urandom), 8'($urandom), "R2 R3 R5 R8 R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule